// File: doc/BRIEF.md
# Four-Channel DMA Controller

This block moves bytes between peripherals and memory so the processor does not have to. While the processor owns the bus, the block is a register slave. Software selects a register with a small select field and loads, for each channel, a 16-bit start address and a 14-bit transfer count. It also writes one mode register that holds the channel enables, the priority scheme and an auto-disable switch.

A peripheral asks for service by raising its request line. The request lines are asynchronous, so the block synchronises them. The block then raises a bus request and waits for the grant. Once granted, it becomes bus master for as long as the winning channel keeps requesting. In that time it drives the low address nibble on its own pins, puts the upper address byte on the data output for an external latch, pulls the winner's acknowledge low, and issues one memory read or write strobe per transfer. On each channel's last transfer it pulses a terminal-count flag. It also pulses a mark flag on every 128th transfer since the count was loaded. Arbitration is either fixed (lowest channel wins) or rotating (the channel last served drops to the bottom).

Top module: `dma4_ctrl`

## Requirements
- R1: After reset `hold` is 0, `bus_master` is 0, all `dack_n` bits are 1, `mem_rd_n` and `mem_wr_n` are 1, `tc` and `mark` are 0, and `dout` is 0.
- R2: A request on an enabled channel raises `hold`. No bus cycle starts, and `bus_master` stays 0, until `hlda` is 1. Requests on channels whose enable bit is 0 are ignored and leave `hold` at 0.
- R3: Register selection works as follows. With `sel[3]`=0, `sel[2:1]` picks the channel and `sel[0]` picks the address (0) or the count (1). Each access goes low byte first and then high byte, stepped by one shared byte pointer. A write at `sel`=8 loads the mode register: bits 3:0 are the channel enables, bit 4 selects rotating priority and bit 5 selects auto-disable. It also clears the pointer. A write at `sel`=9 only clears the pointer. Every register reads back its written value.
- R4: While `bus_master` is 1, `addr_lo` carries address bits 3:0 and `dout` carries address bits 15:8. The channel address increases by one after each transfer.
- R5: During its bus cycles only the winning channel's `dack_n` bit is 0.
- R6: Bits 7:6 of the count high byte set the transfer type. A value of 01 pulses `mem_wr_n` low and 10 pulses `mem_rd_n` low, once per transfer. The two strobes are never low together.
- R7: A channel loaded with count N performs N+1 transfers. `tc` is 1 only during the last of them. With auto-disable set, that transfer clears the channel's enable bit, and the cleared bit can be read back.
- R8: In fixed mode the lowest-numbered requesting channel wins every arbitration.
- R9: In rotating mode channel 0 has the highest priority after reset. Each grant makes the granted channel the lowest priority for the next arbitration.
- R10: `mark` is 1 during the 128th, 256th, ... transfer counted from the last write of the channel's count high byte, and 0 otherwise.
- R11: When the winning request is withdrawn, the burst ends and `hold` returns to 0 within 8 clock cycles.
- R12: Slave register writes are ignored while `bus_master` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Slave chip select, active low |
| wr_n | input | 1 | Slave register write, active low, one access per clock |
| rd_n | input | 1 | Slave register read, active low, one access per clock |
| sel | input | 4 | Slave register select |
| din | input | 8 | Slave write data |
| dout | output | 8 | Slave read data; upper address byte while master |
| dreq | input | 4 | Asynchronous per-channel service requests |
| dack_n | output | 4 | Per-channel acknowledge, active low |
| hold | output | 1 | Bus request to the processor |
| hlda | input | 1 | Bus grant from the processor |
| bus_master | output | 1 | Block drives the memory bus |
| addr_lo | output | 4 | Low address nibble while master |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| tc | output | 1 | Last transfer of the channel's count |
| mark | output | 1 | Every 128th transfer |

## Verification
The transfer engine is exercised in four ways: a single request held off by a withheld grant, two simultaneous requests under fixed priority, repeated paired requests under rotating priority, and one long 300-transfer run. The held-off grant separates the bus request from bus ownership. The paired requests separate fixed from rotating arbitration, because the two schemes pick different winners for the same request pattern. The long run checks address carry across bytes and the 128-transfer mark positions, and short counts of 0 and 2 locate the terminal-count pulse and the auto-disable effect. A request withdrawn in the middle of a burst, with a slave write attempted during it, checks bus release and the lockout of slave writes.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ADDR = 2'd2,
    ST_STRB = 2'd3
  } dma_st_t;

  localparam logic [1:0] XT_WRITE = 2'b01;
  localparam logic [1:0] XT_READ  = 2'b10;
endpackage

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int AW = 16,
  parameter int CW = 14,
  parameter int MW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    din,
  input  logic          ld_addr_lo,
  input  logic          ld_addr_hi,
  input  logic          ld_cnt_lo,
  input  logic          ld_cnt_hi,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] cnt,
  output logic [1:0]    xtype,
  output logic          at_tc,
  output logic          at_mark
);
  localparam logic [AW-1:0] A_ONE = AW'(1);
  localparam logic [CW-1:0] C_ONE = CW'(1);
  localparam logic [MW-1:0] M_ONE = MW'(1);

  logic [AW-1:0] addr_q, addr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [1:0]    typ_q, typ_n;
  logic [MW-1:0] prog_q, prog_n;

  always_comb begin
    addr_n = addr_q;
    cnt_n  = cnt_q;
    typ_n  = typ_q;
    prog_n = prog_q;
    if (ld_addr_lo) addr_n[7:0]    = din;
    if (ld_addr_hi) addr_n[AW-1:8] = din[AW-9:0];
    if (ld_cnt_lo)  cnt_n[7:0]     = din;
    if (ld_cnt_hi) begin
      cnt_n[CW-1:8] = din[CW-9:0];
      typ_n         = din[7:6];
      prog_n        = '0;
    end
    if (step) begin
      addr_n = addr_q + A_ONE;
      cnt_n  = cnt_q - C_ONE;
      prog_n = prog_q + M_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      typ_q  <= '0;
      prog_q <= '0;
    end else begin
      addr_q <= addr_n;
      cnt_q  <= cnt_n;
      typ_q  <= typ_n;
      prog_q <= prog_n;
    end
  end

  assign addr    = addr_q;
  assign cnt     = cnt_q;
  assign xtype   = typ_q;
  assign at_tc   = (cnt_q == '0);
  assign at_mark = (prog_q == {MW{1'b1}});

  // R4: each finished transfer advances the address by exactly one
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr_q == $past(addr_q) + A_ONE));
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dreq_raw,
  input  logic [NCH-1:0] en,
  input  logic           rotate,
  input  logic           take,
  output logic [NCH-1:0] req_sync,
  output logic           any,
  output logic [CHW-1:0] win
);
  logic [NCH-1:0] s1_q, s2_q;
  logic [NCH-1:0] req_m;
  logic [CHW-1:0] last_q, last_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= dreq_raw;
      s2_q <= s1_q;
    end
  end

  assign req_sync = s2_q;
  assign req_m    = s2_q & en;
  assign any      = |req_m;

  // search from the base upward; the last hit in the reverse walk is the first in order
  always_comb begin
    int base;
    int idx;
    base = rotate ? (int'(last_q) + 1) : 0;
    win  = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      idx = (base + k) % NCH;
      if (req_m[idx]) win = CHW'(idx);
    end
  end

  always_comb begin
    last_n = last_q;
    if (take) last_n = win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= CHW'(NCH - 1);
    else        last_q <= last_n;
  end

  // R8: a grant always goes to a channel that is requesting and enabled
  p_grant_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> req_m[win]);
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    any_req,
  input  logic    hlda,
  input  logic    cont,
  output dma_st_t st,
  output logic    take,
  output logic    step
);
  dma_st_t st_q, st_n;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE: if (any_req) st_n = ST_REQ;
      ST_REQ: begin
        if (!any_req)  st_n = ST_IDLE;
        else if (hlda) st_n = ST_ADDR;
      end
      ST_ADDR: st_n = ST_STRB;
      ST_STRB: st_n = cont ? ST_ADDR : ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_n;
  end

  assign st   = st_q;
  assign take = (st_q == ST_REQ) && hlda && any_req;
  assign step = (st_q == ST_STRB);

  // R2: mastership is entered only from a cycle in which the grant was seen
  p_grant_before_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR && $past(st_q) == ST_REQ) |-> $past(hlda));
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 14,
  parameter int MW  = 7,
  localparam int CHW  = $clog2(NCH),
  localparam int SELW = CHW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            wr_n,
  input  logic            rd_n,
  input  logic [SELW-1:0] sel,
  input  logic [7:0]      din,
  output logic [7:0]      dout,
  input  logic [NCH-1:0]  dreq,
  output logic [NCH-1:0]  dack_n,
  output logic            hold,
  input  logic            hlda,
  output logic            bus_master,
  output logic [3:0]      addr_lo,
  output logic            mem_rd_n,
  output logic            mem_wr_n,
  output logic            tc,
  output logic            mark
);
  // slave decode
  logic acc, wr, rd, is_ch, mode_wr, ptr_clr, ch_acc;
  logic [CHW-1:0] rch;

  // control registers
  logic [NCH-1:0] en_q, en_n;
  logic rot_q, rot_n, adis_q, adis_n, ptr_q, ptr_n;
  logic [CHW-1:0] win_q, win_n;

  // channel side
  logic [AW-1:0] ch_addr [NCH];
  logic [CW-1:0] ch_cnt  [NCH];
  logic [1:0]    ch_typ  [NCH];
  logic [NCH-1:0] ch_tc, ch_mark;
  logic [NCH-1:0] ld_al, ld_ah, ld_cl, ld_ch;

  // engine
  logic [NCH-1:0] req_sync;
  logic any_req, take, step, cont, stop;
  logic [CHW-1:0] win;
  dma_st_t st;
  logic [7:0] rdata;

  assign acc     = !cs_n && !bus_master;
  assign wr      = acc && !wr_n;
  assign rd      = acc && !rd_n && wr_n;
  assign is_ch   = !sel[SELW-1];
  assign rch     = sel[CHW:1];
  assign mode_wr = wr && !is_ch && !sel[0];
  assign ptr_clr = wr && !is_ch && sel[0];
  assign ch_acc  = (wr || rd) && is_ch;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      assign hit   = wr && is_ch && (rch == CHW'(c));
      assign ld_al[c] = hit && !sel[0] && !ptr_q;
      assign ld_ah[c] = hit && !sel[0] &&  ptr_q;
      assign ld_cl[c] = hit &&  sel[0] && !ptr_q;
      assign ld_ch[c] = hit &&  sel[0] &&  ptr_q;

      dma_chan #(.AW(AW), .CW(CW), .MW(MW)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .ld_addr_lo(ld_al[c]),
        .ld_addr_hi(ld_ah[c]),
        .ld_cnt_lo (ld_cl[c]),
        .ld_cnt_hi (ld_ch[c]),
        .step      (step && (win_q == CHW'(c))),
        .addr      (ch_addr[c]),
        .cnt       (ch_cnt[c]),
        .xtype     (ch_typ[c]),
        .at_tc     (ch_tc[c]),
        .at_mark   (ch_mark[c])
      );
    end
  endgenerate

  dma_arb #(.NCH(NCH)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .dreq_raw(dreq),
    .en      (en_q),
    .rotate  (rot_q),
    .take    (take),
    .req_sync(req_sync),
    .any     (any_req),
    .win     (win)
  );

  dma_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .any_req(any_req),
    .hlda   (hlda),
    .cont   (cont),
    .st     (st),
    .take   (take),
    .step   (step)
  );

  assign stop = ch_tc[win_q] && adis_q;
  assign cont = req_sync[win_q] && en_q[win_q] && !stop;

  // register next state
  always_comb begin
    en_n   = en_q;
    rot_n  = rot_q;
    adis_n = adis_q;
    ptr_n  = ptr_q;
    win_n  = win_q;
    if (mode_wr) begin
      en_n   = din[NCH-1:0];
      rot_n  = din[NCH];
      adis_n = din[NCH+1];
    end
    if (step && stop) en_n[win_q] = 1'b0;
    if (mode_wr || ptr_clr) ptr_n = 1'b0;
    else if (ch_acc)        ptr_n = !ptr_q;
    if (take) win_n = win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      rot_q  <= 1'b0;
      adis_q <= 1'b0;
      ptr_q  <= 1'b0;
      win_q  <= '0;
    end else begin
      en_q   <= en_n;
      rot_q  <= rot_n;
      adis_q <= adis_n;
      ptr_q  <= ptr_n;
      win_q  <= win_n;
    end
  end

  // slave read mux
  always_comb begin
    rdata = 8'h00;
    if (rd) begin
      if (!is_ch) begin
        if (!sel[0]) rdata = 8'({adis_q, rot_q, en_q});
      end else if (!sel[0]) begin
        rdata = ptr_q ? 8'(ch_addr[rch] >> 8) : ch_addr[rch][7:0];
      end else begin
        rdata = ptr_q ? {ch_typ[rch], 6'(ch_cnt[rch] >> 8)} : ch_cnt[rch][7:0];
      end
    end
  end

  // master outputs
  assign hold       = (st != ST_IDLE);
  assign bus_master = (st == ST_ADDR) || (st == ST_STRB);
  assign dout       = bus_master ? 8'(ch_addr[win_q] >> 8) : rdata;
  assign addr_lo    = bus_master ? ch_addr[win_q][3:0] : 4'h0;
  assign dack_n     = bus_master ? ~(NCH'(1) << win_q) : {NCH{1'b1}};
  assign mem_wr_n   = !(step && ch_typ[win_q] == XT_WRITE);
  assign mem_rd_n   = !(step && ch_typ[win_q] == XT_READ);
  assign tc         = step && ch_tc[win_q];
  assign mark       = step && ch_mark[win_q];

  // R5: never more than one acknowledge active
  p_dack_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n));
  // R6: read and write strobes exclusive
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));
  // R7: the terminal-count pulse lasts a single cycle
  p_tc_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);
  // R12: slave writes cannot alter the mode while the bus is owned
  p_mode_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_master) && $past(!wr_n)) |-> ($stable(rot_q) && $stable(adis_q)));
  // R2: acknowledge only while the bus request is up
  p_dack_needs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_n != {NCH{1'b1}}) |-> hold);
endmodule

// File: tb/sim_dma4_ctrl.sv
`timescale 1ns/1ps
module sim_dma4_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [3:0] sel = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic [3:0] dreq = '0;
  logic [3:0] dack_n;
  logic hold, bus_master, mem_rd_n, mem_wr_n, tc, mark;
  logic hlda = 1'b0;
  logic hlda_en = 1'b1;
  logic [3:0] addr_lo;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // collected transfers
  int n_x;
  int x_ch [512];
  int x_addr_lo [512];
  int x_hi [512];
  bit x_tc [512];
  bit x_mark [512];
  bit x_wr [512];
  bit x_rd [512];

  always #10 clk = ~clk;
  always @(posedge clk) hlda <= hold & hlda_en;

  dma4_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .sel(sel), .din(din), .dout(dout), .dreq(dreq), .dack_n(dack_n),
    .hold(hold), .hlda(hlda), .bus_master(bus_master), .addr_lo(addr_lo),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .tc(tc), .mark(mark)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wr_reg(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk);
    cs_n = 0; wr_n = 0; sel = s; din = d;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic rd_reg(input logic [3:0] s, output logic [7:0] d);
    @(negedge clk);
    cs_n = 0; rd_n = 0; sel = s;
    #5 d = dout;
    @(negedge clk);
    cs_n = 1; rd_n = 1;
  endtask

  task automatic prog(input int ch, input logic [15:0] a, input logic [13:0] n,
                      input logic [1:0] typ);
    wr_reg(4'd9, 8'h00);
    wr_reg(4'(ch * 2), a[7:0]);
    wr_reg(4'(ch * 2), a[15:8]);
    wr_reg(4'(ch * 2 + 1), n[7:0]);
    wr_reg(4'(ch * 2 + 1), {typ, n[13:8]});
  endtask

  function automatic int dack_ch(input logic [3:0] d);
    case (~d)
      4'b0001: return 0;
      4'b0010: return 1;
      4'b0100: return 2;
      4'b1000: return 3;
      default: return -1;
    endcase
  endfunction

  // record every strobe cycle until the bus has been idle for a while
  task automatic collect(input int limit);
    int idle;
    bit seen;
    n_x = 0; idle = 0; seen = 0;
    for (int cyc = 0; cyc < limit; cyc++) begin
      @(negedge clk);
      if (!mem_wr_n || !mem_rd_n) begin
        if (n_x < 512) begin
          x_ch[n_x] = dack_ch(dack_n);
          x_addr_lo[n_x] = int'(addr_lo);
          x_hi[n_x] = int'(dout);
          x_tc[n_x] = tc;
          x_mark[n_x] = mark;
          x_wr[n_x] = !mem_wr_n;
          x_rd[n_x] = !mem_rd_n;
        end
        n_x++;
        seen = 1;
      end
      if (hold) idle = 0; else idle++;
      if (seen && idle >= 4) break;
    end
  endtask

  // one bus tenure: returns the channel of its first transfer
  task automatic tenure(input logic [3:0] m, output int ch);
    ch = -1;
    @(negedge clk);
    dreq = m;
    for (int cyc = 0; cyc < 60; cyc++) begin
      @(negedge clk);
      if (!mem_wr_n || !mem_rd_n) begin ch = dack_ch(dack_n); break; end
    end
    dreq = '0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      if (!hold) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(hold == 0, "R1", "hold", hold, 0);
    chk(bus_master == 0, "R1", "bus_master", bus_master, 0);
    chk(dack_n == 4'hF, "R1", "dack_n", dack_n, 4'hF);
    chk(mem_rd_n && mem_wr_n, "R1", "strobes", {mem_rd_n, mem_wr_n}, 3);
    chk(!tc && !mark, "R1", "tc/mark", {tc, mark}, 0);
    chk(dout == 0, "R1", "dout", dout, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    prog(2, 16'h1234, 14'h0ABC, 2'b01);
    wr_reg(4'd9, 8'h00);
    rd_reg(4'd4, d); chk(d == 8'h34, "R3", "addr lo", d, 8'h34);
    rd_reg(4'd4, d); chk(d == 8'h12, "R3", "addr hi", d, 8'h12);
    rd_reg(4'd5, d); chk(d == 8'hBC, "R3", "count lo", d, 8'hBC);
    rd_reg(4'd5, d); chk(d == 8'h4A, "R3", "count hi", d, 8'h4A);
    wr_reg(4'd8, 8'h2F);
    rd_reg(4'd8, d); chk(d == 8'h2F, "R3", "mode", d, 8'h2F);
    wr_reg(4'd8, 8'h00);
  endtask

  task automatic t_grant_wait();
    logic [7:0] d;
    int bad;
    prog(0, 16'hAB10, 14'd2, 2'b01);
    wr_reg(4'd8, 8'h21);
    hlda_en = 0;
    @(negedge clk); dreq = 4'b0001;
    repeat (10) @(negedge clk);
    chk(hold == 1, "R2", "hold raised", hold, 1);
    chk(bus_master == 0, "R2", "no master before grant", bus_master, 0);
    hlda_en = 1;
    collect(200);
    dreq = '0;
    chk(n_x == 3, "R7", "transfers for count 2", n_x, 3);
    bad = 0;
    for (int i = 0; i < 3 && i < n_x; i++) begin
      if (x_ch[i] != 0 || x_addr_lo[i] != i || x_hi[i] != 'hAB) bad++;
      if (!x_wr[i] || x_rd[i]) bad++;
      if (x_tc[i] != (i == 2)) bad++;
    end
    chk(bad == 0, "R4 R5 R6 R7", "write burst content", bad, 0);
    rd_reg(4'd8, d); chk(d == 8'h20, "R7", "enable cleared", d, 8'h20);
  endtask

  task automatic t_read_type();
    logic [7:0] d;
    prog(1, 16'h0005, 14'd0, 2'b10);
    wr_reg(4'd8, 8'h22);
    @(negedge clk); dreq = 4'b0010;
    collect(200);
    dreq = '0;
    chk(n_x == 1, "R7", "count 0 gives one transfer", n_x, 1);
    chk(x_rd[0] && !x_wr[0], "R6", "read strobe only", {x_rd[0], x_wr[0]}, 2);
    chk(x_tc[0] && x_ch[0] == 1 && x_addr_lo[0] == 5, "R7", "tc on single", x_tc[0], 1);
    rd_reg(4'd8, d); chk(d == 8'h20, "R7", "enable cleared", d, 8'h20);
  endtask

  task automatic t_fixed();
    int bad;
    prog(1, 16'h3000, 14'd1, 2'b01);
    prog(3, 16'h5008, 14'd1, 2'b01);
    wr_reg(4'd8, 8'h2A);
    @(negedge clk); dreq = 4'b1010;
    collect(300);
    dreq = '0;
    chk(n_x == 4, "R8", "total transfers", n_x, 4);
    bad = 0;
    if (n_x == 4) begin
      if (x_ch[0] != 1 || x_ch[1] != 1 || x_ch[2] != 3 || x_ch[3] != 3) bad++;
      if (x_addr_lo[0] != 0 || x_addr_lo[1] != 1 || x_addr_lo[2] != 8 || x_addr_lo[3] != 9) bad++;
      if (x_hi[0] != 'h30 || x_hi[2] != 'h50) bad++;
    end
    chk(bad == 0, "R8", "lower channel served first", bad, 0);
  endtask

  task automatic t_rotate();
    int ch;
    prog(0, 16'h1000, 14'h3FFF, 2'b01);
    prog(1, 16'h2000, 14'h3FFF, 2'b01);
    wr_reg(4'd8, 8'h13);
    tenure(4'b0001, ch); chk(ch == 0, "R9", "lone ch0", ch, 0);
    tenure(4'b0011, ch); chk(ch == 1, "R9", "ch0 demoted", ch, 1);
    tenure(4'b0011, ch); chk(ch == 0, "R9", "ch1 demoted", ch, 0);
    wr_reg(4'd8, 8'h03);
    tenure(4'b0011, ch); chk(ch == 0, "R8", "fixed pair first", ch, 0);
    tenure(4'b0011, ch); chk(ch == 0, "R8", "fixed pair again", ch, 0);
  endtask

  task automatic t_mark();
    int nm, bad;
    prog(3, 16'h0000, 14'd299, 2'b01);
    wr_reg(4'd8, 8'h28);
    @(negedge clk); dreq = 4'b1000;
    collect(2000);
    dreq = '0;
    chk(n_x == 300, "R7", "long run length", n_x, 300);
    nm = 0; bad = 0;
    for (int i = 0; i < n_x && i < 512; i++) begin
      if (x_mark[i]) begin
        nm++;
        if (i != 127 && i != 255) bad++;
      end
      if (x_tc[i] != (i == 299)) bad++;
    end
    chk(nm == 2, "R10", "mark count", nm, 2);
    chk(bad == 0, "R10", "mark/tc positions", bad, 0);
    bad = 0;
    for (int i = 0; i < n_x && i < 512; i++)
      if (x_addr_lo[i] != (i & 15) || x_hi[i] != (i >> 8)) bad++;
    chk(bad == 0, "R4", "address carry across bytes", bad, 0);
  endtask

  task automatic t_release();
    logic [7:0] d;
    int wait_c;
    prog(2, 16'h7700, 14'h3FFF, 2'b01);
    wr_reg(4'd8, 8'h04);
    @(negedge clk); dreq = 4'b0001;
    repeat (10) @(negedge clk);
    chk(hold == 0, "R2", "disabled channel ignored", hold, 0);
    dreq = 4'b0100;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      if (bus_master) break;
    end
    wr_reg(4'd8, 8'h00);
    chk(bus_master == 1, "R12", "write landed in burst", bus_master, 1);
    dreq = '0;
    wait_c = 0;
    for (int cyc = 0; cyc < 20; cyc++) begin
      @(negedge clk);
      if (!hold) break;
      wait_c++;
    end
    chk(wait_c < 8, "R11", "hold release cycles", wait_c, 8);
    repeat (3) @(negedge clk);
    rd_reg(4'd8, d); chk(d == 8'h04, "R12", "mode unchanged", d, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_grant_wait();
    t_read_type();
    t_fixed();
    t_rotate();
    t_mark();
    t_release();
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule